// File: doc/BRIEF.md
# SPI master with two-stage bit-clock divider

This block is a register-programmed synchronous serial master that sits on a simple single-cycle register bus. Software places frames into an 8-entry transmit queue through a data register. An engine pops each frame, shifts it out most significant bit first on the serial clock and data-out lines, and collects the data-in line into an 8-entry receive queue. Software reads the received frames back through the same data register. The chip-select line is a plain control bit that software drives. It is never sequenced by hardware, so one select window can span any number of frames.

The bit clock is produced in two stages. An even prescale value divides the system clock first. A rate field in control register 0 then multiplies that period by (1 + rate). Frame width runs from 4 to 16 bits and is programmed as width minus one. All four polarity and phase combinations are available. A loopback bit feeds the transmit shifter straight into the receiver and keeps the data-out pin quiet. Status flags report queue levels and activity. Four interrupt sources pass through a mask to a single interrupt line: transmit level, receive level, receive timeout and receive overrun.

Register word addresses on `bus_addr`: 0 control 0, 1 control 1, 2 data, 3 status, 4 prescale, 5 interrupt mask, 6 raw interrupt, 7 masked interrupt, 8 interrupt clear.

Top module: `spi_master_ctrl`

## Requirements
- R1: After reset:
  - status (address 3) reads 0x000B;
  - control 1 (address 1) reads 0x0010;
  - prescale (address 4) reads 0x0002;
  - `cs_n` is 1 and `sclk` is 0.
  Every read returns its data on `bus_rdata` in the cycle after `bus_sel` is sampled with `bus_wr` low.
- R2: One full serial bit lasts PSC × (1 + RATE) system clocks. PSC is the even value in prescale bits 7:0. RATE is control 0 bits 15:8.
- R3: Control 0 bits 3:0 hold the frame width minus one. 0x3 gives 4 bits and 0xF gives 16 bits. Bits are sent MSB first, starting from bit width−1 of the written word. Received frames are read back right-justified, with the upper bits zero.
- R4: Control 0 bit 6 is the polarity, and `sclk` idles at its value. Control 0 bit 7 is the phase:
  - phase 0: data-in is sampled on the leading edge of each bit and data-out changes on the trailing edge;
  - phase 1: data-in is sampled on the trailing edge of each bit.
- R5: Control 1 bit 0 is loopback. With it set, the receiver captures the transmit shifter output and `mosi` stays 0.
- R6: Status bits are:
  - bit 0: transmit queue empty;
  - bit 1: transmit queue not full;
  - bit 2: receive queue not empty;
  - bit 3: receive queue not full;
  - bit 4: busy.
  Each queue holds 8 frames. A write to the data register while the transmit queue is full is discarded.
- R7: A frame that completes while the receive queue is full is dropped, and raw interrupt bit 0 (overrun) is set. Writing 1 to clear-register bit 0 clears that flag.
- R8: Raw interrupt bit 3 is set while the transmit queue holds 4 or fewer frames. Raw interrupt bit 2 is set while the receive queue holds 4 or more frames. The masked register equals raw AND mask (same bit order), and `irq` is the OR of the masked bits, registered.
- R9: Raw interrupt bit 1 (timeout) is set when the receive queue stays non-empty for TMO_CYC (default 32) clocks with no push and no read. Writing 1 to clear-register bit 1 clears it.
- R10: Control 1 bit 1 enables the port, and frames start only while it is 1. Clearing it lets the frame in flight finish and starts no further frame. Busy is set while a frame shifts, or while the port is enabled and the transmit queue is not empty.
- R11: `cs_n` follows control 1 bit 4, one clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, software controlled |
| irq | output | 1 | Combined masked interrupt |

## Verification
The embedded checks assume the following about the inputs:
- every bus access lasts exactly one cycle;
- the prescale value stays even and at least 2;
- the configuration is not rewritten while a frame is in flight.

The bench keeps to these conditions by using one-cycle access tasks and programming only even prescales. It changes the mode, width or divider only after status reports the port idle. The data-in line is driven either as 0 or as the inverse of data-out. That lets non-loopback receive values be predicted with no model of the engine's timing.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W = 16;
  localparam logic [3:0] A_CTRL0 = 4'd0;
  localparam logic [3:0] A_CTRL1 = 4'd1;
  localparam logic [3:0] A_DATA  = 4'd2;
  localparam logic [3:0] A_STAT  = 4'd3;
  localparam logic [3:0] A_PSC   = 4'd4;
  localparam logic [3:0] A_MASK  = 4'd5;
  localparam logic [3:0] A_RAW   = 4'd6;
  localparam logic [3:0] A_MIS   = 4'd7;
  localparam logic [3:0] A_CLR   = 4'd8;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int PSC_W = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PSC_W-1:0]  psc,
  input  logic [RATE_W-1:0] rate,
  output logic              half_tick
);
  localparam int HW = PSC_W - 1;
  logic [HW-1:0] half, p_lim, p_cnt;
  logic [RATE_W-1:0] s_cnt;

  assign half  = (psc[PSC_W-1:1] == '0) ? HW'(1) : psc[PSC_W-1:1];
  assign p_lim = half - 1'b1;
  assign half_tick = run && (p_cnt == p_lim) && (s_cnt == rate);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      p_cnt <= '0;
      s_cnt <= '0;
    end else if (p_cnt == p_lim) begin
      p_cnt <= '0;
      s_cnt <= (s_cnt == rate) ? '0 : s_cnt + 1'b1;
    end else begin
      p_cnt <= p_cnt + 1'b1;
    end
  end

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (half_tick && psc >= PSC_W'(4)) |=> (!half_tick || psc != $past(psc)));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int W = 16,
  localparam int NW = $clog2(W),
  localparam int HW = NW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          loop,
  input  logic [NW-1:0] width_m1,
  input  logic          tx_empty,
  input  logic [W-1:0]  tx_data,
  output logic          tx_pop,
  input  logic          miso,
  input  logic          half_tick,
  output logic          active,
  output logic          rx_push,
  output logic [W-1:0]  rx_data,
  output logic          sclk,
  output logic          mosi
);
  logic [NW-1:0] nb;
  logic [HW-1:0] h, last;
  logic [W-1:0] shreg, rxs, rx_next, rmask;
  logic sclk_ph, lead, do_smp, do_shf, rx_bit;

  assign nb      = (width_m1 < NW'(3)) ? NW'(3) : width_m1;
  assign last    = {nb, 1'b1};
  assign rmask   = {W{1'b1}} >> (NW'(W - 1) - nb);
  assign tx_pop  = !active && en && !tx_empty;
  assign lead    = !h[0];
  assign do_smp  = cpha ? !lead : lead;
  assign do_shf  = cpha ? (lead && h != '0) : !lead;
  assign rx_bit  = loop ? shreg[W-1] : miso;
  assign rx_next = {rxs[W-2:0], rx_bit};
  assign sclk    = active ? (sclk_ph ^ cpol) : cpol;
  assign mosi    = loop ? 1'b0 : shreg[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      h <= '0;
      sclk_ph <= 1'b0;
      shreg <= '0;
      rxs <= '0;
      rx_push <= 1'b0;
      rx_data <= '0;
    end else begin
      rx_push <= 1'b0;
      if (tx_pop) begin
        active <= 1'b1;
        h <= '0;
        sclk_ph <= 1'b0;
        shreg <= tx_data << (NW'(W - 1) - nb);
        rxs <= '0;
      end else if (active && half_tick) begin
        sclk_ph <= ~sclk_ph;
        if (do_smp) rxs <= rx_next;
        if (do_shf) shreg <= shreg << 1;
        if (h == last) begin
          active <= 1'b0;
          rx_push <= 1'b1;
          rx_data <= (do_smp ? rx_next : rxs) & rmask;
        end else begin
          h <= h + 1'b1;
        end
      end
    end
  end

  assert_push_after_frame_R3: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> ($past(active) && !active));
  assert_start_on_pop_R10: assert property (@(posedge clk) disable iff (rst)
    tx_pop |=> active);
endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
  import spim_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TX_LVL = 4,
  parameter int RX_LVL = 4,
  parameter int TMO_CYC = 32,
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int TW = $clog2(TMO_CYC + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  output logic        irq
);
  logic [15:0] ctrl0;
  logic [4:0]  ctrl1;
  logic [7:0]  psc;
  logic [3:0]  imask, raw, mis;
  logic        ovr_f, tmo_f;
  logic [TW-1:0] tmr;
  logic wr_hit, rd_hit, tx_push, rx_pop;
  logic tx_pop, tx_full, tx_empty, rx_push, rx_full, rx_empty, active, half_tick, busy;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DATA_W-1:0] tx_head, rx_head, rx_frame;
  logic [4:0] status;

  assign wr_hit  = bus_sel && bus_wr;
  assign rd_hit  = bus_sel && !bus_wr;
  assign tx_push = wr_hit && bus_addr == A_DATA;
  assign rx_pop  = rd_hit && bus_addr == A_DATA;
  assign busy    = active || (ctrl1[1] && !tx_empty);
  assign status  = {busy, !rx_full, !rx_empty, !tx_full, tx_empty};
  assign raw     = {tx_cnt <= CW'(TX_LVL), rx_cnt >= CW'(RX_LVL), tmo_f, ovr_f};
  assign mis     = raw & imask;

  spim_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .wdata(bus_wdata), .pop(tx_pop),
    .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_frame), .pop(rx_pop),
    .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spim_clkdiv #(.PSC_W(8), .RATE_W(8)) u_div (
    .clk(clk), .rst(rst), .run(active), .psc(psc), .rate(ctrl0[15:8]),
    .half_tick(half_tick));

  spim_shifter #(.W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .en(ctrl1[1]), .cpol(ctrl0[6]), .cpha(ctrl0[7]),
    .loop(ctrl1[0]), .width_m1(ctrl0[3:0]), .tx_empty(tx_empty), .tx_data(tx_head),
    .tx_pop(tx_pop), .miso(miso), .half_tick(half_tick), .active(active),
    .rx_push(rx_push), .rx_data(rx_frame), .sclk(sclk), .mosi(mosi));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl0 <= '0;
      ctrl1 <= 5'h10;
      psc   <= 8'd2;
      imask <= '0;
      cs_n  <= 1'b1;
    end else begin
      cs_n <= ctrl1[4];
      if (wr_hit) begin
        case (bus_addr)
          A_CTRL0: ctrl0 <= bus_wdata;
          A_CTRL1: ctrl1 <= bus_wdata[4:0];
          A_PSC:   psc   <= bus_wdata[7:0];
          A_MASK:  imask <= bus_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr <= '0;
      tmo_f <= 1'b0;
      ovr_f <= 1'b0;
      irq <= 1'b0;
    end else begin
      irq <= |mis;
      if (rx_empty || rx_pop || rx_push) tmr <= '0;
      else if (tmr != TW'(TMO_CYC)) tmr <= tmr + 1'b1;
      if (wr_hit && bus_addr == A_CLR && bus_wdata[1]) tmo_f <= 1'b0;
      if (wr_hit && bus_addr == A_CLR && bus_wdata[0]) ovr_f <= 1'b0;
      if (!rx_empty && !rx_pop && !rx_push && tmr == TW'(TMO_CYC - 1)) tmo_f <= 1'b1;
      if (rx_push && rx_full) ovr_f <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd_hit) begin
      case (bus_addr)
        A_CTRL0: bus_rdata <= ctrl0;
        A_CTRL1: bus_rdata <= {11'd0, ctrl1};
        A_DATA:  bus_rdata <= rx_empty ? '0 : rx_head;
        A_STAT:  bus_rdata <= {11'd0, status};
        A_PSC:   bus_rdata <= {8'd0, psc};
        A_MASK:  bus_rdata <= {12'd0, imask};
        A_RAW:   bus_rdata <= {12'd0, raw};
        A_MIS:   bus_rdata <= {12'd0, mis};
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(raw & imask) != 4'd0));
  assert_timeout_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_f) |-> $past(!rx_empty));
  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_f) |-> $past(rx_full));
endmodule

// File: tb/spi_master_ctrl_bench.sv
`timescale 1ns/1ps
module spi_master_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  wire [15:0] bus_rdata;
  wire sclk, mosi, cs_n, irq;
  logic ext_inv = 1'b0;
  wire miso = ext_inv ? ~mosi : 1'b0;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;

  spi_master_ctrl u_spi_master_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .irq(irq));

  always @(posedge clk) cyc <= cyc + 1;

  // edge monitor: captures mosi on the sampling edge of the programmed mode
  logic mon_pol = 1'b0, mon_pha = 1'b0;
  logic [15:0] mon = '0;
  logic sclk_q = 1'b0;
  int rise_prev = 0, rise_last = 0;
  always @(negedge clk) begin
    if (sclk !== sclk_q) begin
      if (sclk == (mon_pol ^ ~mon_pha)) mon = {mon[14:0], mosi};
      if (sclk) begin
        rise_prev = rise_last;
        rise_last = cyc;
      end
    end
    sclk_q = sclk;
  end

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(4'd3, s);
      if (!s[4]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] rate, input logic pha, input logic pol,
                     input logic [3:0] wm1, input logic loop, input logic en,
                     input logic [7:0] p);
    wr(4'd0, {rate, pha, pol, 2'b00, wm1});
    wr(4'd4, {8'd0, p});
    wr(4'd1, {11'd0, 1'b1, 2'b00, en, loop});
    mon_pol = pol; mon_pha = pha;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1 sclk idle", sclk, 0);
    check("R1 cs_n", cs_n, 1);
    rd(4'd3, d); check("R1 status", d, 16'h000B);
    rd(4'd1, d); check("R1 ctrl1", d, 16'h0010);
    rd(4'd4, d); check("R1 prescale", d, 16'h0002);
  endtask

  task automatic t_cs();
    wr(4'd1, 16'h0000);
    @(negedge clk); check("R11 cs low", cs_n, 0);
    wr(4'd1, 16'h0010);
    @(negedge clk); check("R11 cs high", cs_n, 1);
  endtask

  task automatic t_loop8();
    logic [15:0] d;
    logic mosi_seen;
    cfg(8'd0, 1'b0, 1'b0, 4'h7, 1'b1, 1'b1, 8'd2);
    wr(4'd2, 16'h00A5);
    mosi_seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      mosi_seen = mosi_seen | mosi;
    end
    wait_idle();
    check("R5 mosi quiet in loopback", mosi_seen, 0);
    rd(4'd2, d); check("R5 loopback frame", d, 16'h00A5);
  endtask

  task automatic t_widths();
    logic [15:0] d;
    cfg(8'd0, 1'b0, 1'b0, 4'h3, 1'b1, 1'b1, 8'd2);
    wr(4'd2, 16'hFFF6); wait_idle();
    rd(4'd2, d); check("R3 width 4 right-justified", d, 16'h0006);
    cfg(8'd0, 1'b1, 1'b0, 4'hF, 1'b1, 1'b1, 8'd2);
    wr(4'd2, 16'hBEEF); wait_idle();
    rd(4'd2, d); check("R3 width 16", d, 16'hBEEF);
    cfg(8'd0, 1'b0, 1'b1, 4'hB, 1'b1, 1'b1, 8'd2);
    wr(4'd2, 16'h5A3C); wait_idle();
    rd(4'd2, d); check("R3 width 12", d, 16'h0A3C);
  endtask

  task automatic t_modes();
    logic [15:0] d;
    ext_inv = 1'b1;
    for (int m = 0; m < 4; m++) begin
      cfg(8'd1, m[0], m[1], 4'h7, 1'b0, 1'b0, 8'd2);
      repeat (2) @(negedge clk);
      check($sformatf("R4 idle level mode %0d", m), sclk, m[1]);
      wr(4'd2, 16'h005C);
      wr(4'd1, 16'h0012);
      wait_idle();
      check($sformatf("R4 mosi bits mode %0d", m), mon[7:0], 8'h5C);
      rd(4'd2, d);
      check($sformatf("R4 miso capture mode %0d", m), d, 16'h00A3);
    end
    ext_inv = 1'b0;
  endtask

  task automatic t_rate();
    logic [15:0] d;
    cfg(8'd2, 1'b0, 1'b0, 4'hF, 1'b1, 1'b1, 8'd4);
    wr(4'd2, 16'h1234); wait_idle();
    check("R2 period psc4 rate2", rise_last - rise_prev, 12);
    rd(4'd2, d);
    cfg(8'd0, 1'b0, 1'b0, 4'hF, 1'b1, 1'b1, 8'd2);
    wr(4'd2, 16'h1234); wait_idle();
    check("R2 period psc2 rate0", rise_last - rise_prev, 2);
    rd(4'd2, d);
    cfg(8'd0, 1'b0, 1'b0, 4'hF, 1'b1, 1'b1, 8'd6);
    wr(4'd2, 16'h1234); wait_idle();
    check("R2 period psc6 rate0", rise_last - rise_prev, 6);
    rd(4'd2, d);
  endtask

  task automatic t_fifo();
    logic [15:0] d;
    cfg(8'd0, 1'b0, 1'b0, 4'h7, 1'b1, 1'b0, 8'd2);
    for (int i = 1; i <= 8; i++) wr(4'd2, 16'(i));
    wr(4'd2, 16'h00EE);
    rd(4'd3, d); check("R6 status tx full", d, 16'h0008);
    rd(4'd6, d); check("R8 tx level off when 8 queued", d[3], 0);
    wr(4'd1, 16'h0013);
    repeat (3) @(negedge clk);
    wr(4'd2, 16'h0009);
    wait_idle();
    rd(4'd6, d); check("R7 overrun flag", d[0], 1);
    check("R8 rx level flag", d[2], 1);
    rd(4'd3, d); check("R6 status rx full", d, 16'h0007);
    for (int i = 1; i <= 8; i++) begin
      rd(4'd2, d);
      check($sformatf("R6 queue order %0d", i), d, i);
    end
    wr(4'd8, 16'h0001);
    rd(4'd6, d); check("R7 overrun cleared", d[0], 0);
    check("R8 rx level off when empty", d[2], 0);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(4'd8, 16'h0003);
    rd(4'd6, d); check("R8 raw tx level", d, 16'h0008);
    wr(4'd5, 16'h0008);
    repeat (2) @(negedge clk);
    check("R8 irq on", irq, 1);
    rd(4'd7, d); check("R8 masked", d, 16'h0008);
    wr(4'd5, 16'h0004);
    repeat (2) @(negedge clk);
    check("R8 irq off", irq, 0);
    rd(4'd7, d); check("R8 masked off", d, 16'h0000);
    wr(4'd5, 16'h0000);
  endtask

  task automatic t_timeout();
    logic [15:0] d;
    cfg(8'd0, 1'b0, 1'b0, 4'h7, 1'b1, 1'b1, 8'd2);
    wr(4'd8, 16'h0003);
    wr(4'd2, 16'h0042);
    wait_idle();
    rd(4'd6, d); check("R9 no early timeout", d[1], 0);
    repeat (40) @(negedge clk);
    rd(4'd6, d); check("R9 timeout set", d[1], 1);
    rd(4'd2, d); check("R9 frame kept", d, 16'h0042);
    wr(4'd8, 16'h0002);
    rd(4'd6, d); check("R9 timeout cleared", d[1], 0);
  endtask

  task automatic t_stop();
    logic [15:0] d;
    cfg(8'd3, 1'b0, 1'b0, 4'h7, 1'b1, 1'b0, 8'd8);
    wr(4'd2, 16'h0011);
    wr(4'd2, 16'h0022);
    wr(4'd1, 16'h0013);
    repeat (20) @(negedge clk);
    rd(4'd3, d); check("R10 busy while shifting", d[4], 1);
    wr(4'd1, 16'h0011);
    repeat (600) @(negedge clk);
    rd(4'd3, d); check("R10 stopped after one frame", d, 16'h000E);
    rd(4'd2, d); check("R10 finished frame", d, 16'h0011);
    wr(4'd1, 16'h0013);
    wait_idle();
    rd(4'd2, d); check("R10 resumed frame", d, 16'h0022);
  endtask

  initial begin
    t_reset();
    t_cs();
    t_loop8();
    t_widths();
    t_modes();
    t_rate();
    t_fifo();
    t_irq();
    t_timeout();
    t_stop();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule